// File: doc/BRIEF.md
# Chunked Register Multiplexer with Atomic Shadows

This block sits at the end of a narrow register bus and fans it out to a fixed set of register elements. The bus carries an address, a read strobe with read data, and a write strobe with write data. Each element has a width that is fixed at elaboration time. An element may be readable, writable or both. An element wider than the bus data width takes several consecutive bus addresses. Each of these addresses is one chunk of the element, with the least significant chunk at the lowest address.

Wide accesses are atomic. A read of chunk 0 pulses the element's read strobe and captures the whole element into a read shadow. Reads of the higher chunks are served from that copy. Writes to the lower chunks go into a write shadow. A write to the element's last used chunk hands the assembled value to the element together with a one-cycle write strobe.

The address map is computed from parameters. Elements are placed in order. Each element's span is rounded up to a multiple of 2^ALIGN addresses.

A single phase register records what the previous bus cycle did. It has four named states:
- PH_IDLE: no strobe.
- PH_READ: read data is due on the bus.
- PH_FILL: a write was stored in a shadow or ignored.
- PH_COMMIT: an element write strobe is high.

The transitions are taken on every clock edge, from any state, in priority order:
- go_commit: a write strobe to a writable element's last chunk leads to PH_COMMIT.
- go_fill: any other write strobe leads to PH_FILL.
- go_read: a read strobe without a write strobe leads to PH_READ.
- go_idle: no strobe leads to PH_IDLE.

Top module: `csr_chunk_mux`

## Requirements
- R1: Element k needs n_k = ceil(ELEM_W[k]/DATA_W) chunks. Its span is n_k rounded up to a multiple of 2^ALIGN. Its base is the sum of the spans of elements 0..k-1, and chunk c sits at address base+c. With the defaults (widths 4, 8, 16, 20; DATA_W 8; ALIGN 1), the bases are 0, 2, 4 and 6, and element 3 uses addresses 6, 7 and 8.
- R2: When bus_r_stb is high, bus_w_stb is low and bus_addr is the chunk-0 address of a readable element, that element's elem_r_stb bit is high in the same cycle. In that cycle every other elem_r_stb bit is low. A read of any other chunk raises no elem_r_stb bit.
- R3: bus_r_data carries the requested chunk in the cycle after the read strobe and is zero in every other cycle. Chunk 0 returns bits [DATA_W-1:0] of the live element value. Chunk c > 0 returns bits [c*DATA_W +: DATA_W] of the value captured at the last chunk-0 read. Bits above the element width read as zero.
- R4: Reads may be issued in consecutive cycles to different addresses. Each read's data appears one cycle after its own strobe.
- R5: A write to a chunk below the last used chunk of a writable element only stores the data in that element's write shadow. It raises no elem_w_stb bit and leaves elem_w_data unchanged.
- R6: A write to the last used chunk of a writable element sets that element's elem_w_data slot to {bus_w_data, shadow chunks} truncated to the element width. elem_w_stb for that element is high in exactly the following cycle, whatever the address does next.
- R7: Reads of padding addresses and unmapped addresses return zero and raise no strobe. Writes to them change no output.
- R8: Elements 0, 2 and 3 are readable and elements 1, 2 and 3 are writable (bit k of CAN_READ and CAN_WRITE). A read-only element never raises elem_w_stb, and its elem_w_data slot is zero. A write-only element never raises elem_r_stb, and reads of it return zero.
- R9: When bus_r_stb and bus_w_stb are high together, the write is performed and the read is dropped: no elem_r_stb, and zero read data.
- R10: While reset is held low and right after it, elem_w_stb, elem_w_data, bus_r_data and all shadows are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus chunk address |
| bus_r_stb | input | 1 | Bus read strobe |
| bus_r_data | output | DATA_W | Read data, valid the cycle after the read strobe |
| bus_w_stb | input | 1 | Bus write strobe |
| bus_w_data | input | DATA_W | Bus write data |
| elem_r_data | input | NUM_ELEM*SLOT_W | Element values; element k in slot k, low ELEM_W[k] bits |
| elem_r_stb | output | NUM_ELEM | Per-element read strobe, same cycle as the chunk-0 read |
| elem_w_data | output | NUM_ELEM*SLOT_W | Committed element values; element k in slot k |
| elem_w_stb | output | NUM_ELEM | Per-element one-cycle write strobe |

## Verification
An element read strobe is combinational, so the bench samples it one time step after driving the strobe, within the same cycle. Read data and element write strobes both pass through one register. They are sampled at the falling edge after the strobe edge. At that point the bench has already moved the address away, so the check shows that the result does not depend on the address being held. A second sample one cycle later checks that the read data has returned to zero and the write strobe has fallen. The bench sweeps every address with both reads and writes and computes the expected map, the chunks and the assembled values from the arithmetic in the requirements. It changes the element values between reads, so that higher chunks can only match if they come from the captured copy.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_READ   = 2'd1,
        PH_FILL   = 2'd2,
        PH_COMMIT = 2'd3
    } phase_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int round_pow2(input int value, input int align);
        int gran;
        gran = 1 << align;
        return ((value + gran - 1) / gran) * gran;
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_ELEM = 4,
    parameter int ALIGN    = 1,
    parameter int CHUNK_IW = 2,
    parameter int ELEM_W [NUM_ELEM] = '{4, 8, 16, 20}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr,
    output logic [NUM_ELEM-1:0]          hit,
    output logic [NUM_ELEM-1:0]          first,
    output logic [NUM_ELEM-1:0]          last,
    output logic [NUM_ELEM*CHUNK_IW-1:0] chunk_flat
);
    import csr_mux_pkg::*;

    function automatic int base_of(input int idx);
        int acc;
        acc = 0;
        for (int i = 0; i < idx; i++) begin
            acc += round_pow2(ceil_div(ELEM_W[i], DATA_W), ALIGN);
        end
        return acc;
    endfunction

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        localparam int BASE = base_of(e);
        localparam int NCH  = ceil_div(ELEM_W[e], DATA_W);

        logic [ADDR_W:0] off;
        logic            above;

        assign above = ({1'b0, addr} >= (ADDR_W+1)'(BASE));
        assign off   = {1'b0, addr} - (ADDR_W+1)'(BASE);
        assign hit[e]   = above && (off < (ADDR_W+1)'(NCH));
        assign first[e] = above && (off == '0);
        assign last[e]  = above && (off == (ADDR_W+1)'(NCH - 1));
        assign chunk_flat[e*CHUNK_IW +: CHUNK_IW] = off[CHUNK_IW-1:0];
    end

    // R1: spans never overlap, so at most one element claims an address
    assert_single_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R1: first and last chunks are always inside an element's span
    assert_edges_inside_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((first | last) & ~hit) == '0);

endmodule

// File: rtl/csr_elem_shadow.sv
module csr_elem_shadow #(
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 20,
    parameter int W        = 16,
    parameter int NCH      = 2,
    parameter int CHUNK_IW = 2,
    parameter bit CAN_RD   = 1'b1,
    parameter bit CAN_WR   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_first,
    input  logic                wr_fill,
    input  logic                wr_commit,
    input  logic [CHUNK_IW-1:0] chunk,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [SLOT_W-1:0]   elem_rdata,
    output logic [DATA_W-1:0]   rd_word,
    output logic [SLOT_W-1:0]   elem_wdata
);
    localparam int PAD_W = NCH * DATA_W;

    logic unused_inputs;
    assign unused_inputs = ^{chunk, wr_fill, wr_commit, rd_first, bus_wdata, elem_rdata};

    if (CAN_RD) begin : g_read
        logic [W-1:0]     snap_q;
        logic [PAD_W-1:0] live_pad;
        logic [PAD_W-1:0] snap_pad;
        logic [PAD_W-1:0] src;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q <= '0;
            end else if (rd_first) begin
                snap_q <= elem_rdata[W-1:0];
            end
        end

        assign live_pad = PAD_W'(elem_rdata[W-1:0]);
        assign snap_pad = PAD_W'(snap_q);

        always_comb begin
            src     = (chunk == '0) ? live_pad : snap_pad;
            rd_word = '0;
            for (int c = 0; c < NCH; c++) begin
                if (chunk == CHUNK_IW'(c)) begin
                    rd_word = src[c*DATA_W +: DATA_W];
                end
            end
        end

        // R3: the captured copy only moves on a chunk-0 read
        assert_snap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_first |=> $stable(snap_q));
    end else begin : g_no_read
        assign rd_word = '0;
    end

    if (CAN_WR) begin : g_write
        logic [W-1:0] wdata_q;

        if (NCH > 1) begin : g_multi
            logic [(NCH-1)*DATA_W-1:0] wsh_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wsh_q <= '0;
                end else if (wr_fill) begin
                    for (int c = 0; c < NCH - 1; c++) begin
                        if (chunk == CHUNK_IW'(c)) begin
                            wsh_q[c*DATA_W +: DATA_W] <= bus_wdata;
                        end
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wdata_q <= '0;
                end else if (wr_commit) begin
                    wdata_q <= W'({bus_wdata, wsh_q});
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wdata_q <= '0;
                end else if (wr_commit) begin
                    wdata_q <= W'(bus_wdata);
                end
            end
        end

        assign elem_wdata = SLOT_W'(wdata_q);

        // R5: the element value only changes on a last-chunk write
        assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_commit |=> $stable(wdata_q));
    end else begin : g_no_write
        assign elem_wdata = '0;
    end

endmodule

// File: rtl/csr_chunk_mux.sv
module csr_chunk_mux #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int NUM_ELEM = 4,
    parameter int ALIGN    = 1,
    parameter int SLOT_W   = 20,
    parameter int ELEM_W [NUM_ELEM] = '{4, 8, 16, 20},
    parameter bit [NUM_ELEM-1:0] CAN_READ  = 4'b1101,
    parameter bit [NUM_ELEM-1:0] CAN_WRITE = 4'b1110
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_r_stb,
    output logic [DATA_W-1:0]          bus_r_data,
    input  logic                       bus_w_stb,
    input  logic [DATA_W-1:0]          bus_w_data,
    input  logic [NUM_ELEM*SLOT_W-1:0] elem_r_data,
    output logic [NUM_ELEM-1:0]        elem_r_stb,
    output logic [NUM_ELEM*SLOT_W-1:0] elem_w_data,
    output logic [NUM_ELEM-1:0]        elem_w_stb
);
    import csr_mux_pkg::*;

    localparam int MAX_CH   = ceil_div(SLOT_W, DATA_W);
    localparam int CHUNK_IW = $clog2(MAX_CH + 1);

    logic [NUM_ELEM-1:0]          hit;
    logic [NUM_ELEM-1:0]          first;
    logic [NUM_ELEM-1:0]          last;
    logic [NUM_ELEM*CHUNK_IW-1:0] chunk_flat;
    logic [NUM_ELEM*DATA_W-1:0]   word_flat;
    logic [NUM_ELEM-1:0]          rd_first;
    logic [NUM_ELEM-1:0]          wr_fill;
    logic [NUM_ELEM-1:0]          wr_commit;
    logic                         rd_go;
    logic                         wr_go;
    logic [DATA_W-1:0]            sel_word;

    phase_e                       phase_q;
    phase_e                       phase_d;
    logic [DATA_W-1:0]            rdata_q;
    logic [NUM_ELEM-1:0]          commit_q;

    assign wr_go = bus_w_stb;
    assign rd_go = bus_r_stb && !bus_w_stb;

    csr_addr_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_ELEM (NUM_ELEM),
        .ALIGN    (ALIGN),
        .CHUNK_IW (CHUNK_IW),
        .ELEM_W   (ELEM_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .hit        (hit),
        .first      (first),
        .last       (last),
        .chunk_flat (chunk_flat)
    );

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
        localparam int NCH = ceil_div(ELEM_W[e], DATA_W);

        assign rd_first[e]  = rd_go && first[e] && CAN_READ[e];
        assign wr_fill[e]   = wr_go && hit[e] && !last[e] && CAN_WRITE[e];
        assign wr_commit[e] = wr_go && last[e] && CAN_WRITE[e];

        csr_elem_shadow #(
            .DATA_W   (DATA_W),
            .SLOT_W   (SLOT_W),
            .W        (ELEM_W[e]),
            .NCH      (NCH),
            .CHUNK_IW (CHUNK_IW),
            .CAN_RD   (CAN_READ[e]),
            .CAN_WR   (CAN_WRITE[e])
        ) u_shadow (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_first   (rd_first[e]),
            .wr_fill    (wr_fill[e]),
            .wr_commit  (wr_commit[e]),
            .chunk      (chunk_flat[e*CHUNK_IW +: CHUNK_IW]),
            .bus_wdata  (bus_w_data),
            .elem_rdata (elem_r_data[e*SLOT_W +: SLOT_W]),
            .rd_word    (word_flat[e*DATA_W +: DATA_W]),
            .elem_wdata (elem_w_data[e*SLOT_W +: SLOT_W])
        );
    end

    assign elem_r_stb = rd_first;

    always_comb begin
        sel_word = '0;
        for (int e = 0; e < NUM_ELEM; e++) begin
            if (hit[e]) begin
                sel_word = sel_word | word_flat[e*DATA_W +: DATA_W];
            end
        end
    end

    // Next phase: commit beats fill, fill beats read
    always_comb begin
        phase_d = PH_IDLE;
        if (|wr_commit) begin
            phase_d = PH_COMMIT;
        end else if (wr_go) begin
            phase_d = PH_FILL;
        end else if (rd_go) begin
            phase_d = PH_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            rdata_q  <= '0;
            commit_q <= '0;
        end else begin
            phase_q  <= phase_d;
            rdata_q  <= rd_go ? sel_word : '0;
            commit_q <= wr_commit;
        end
    end

    always_comb begin
        bus_r_data = '0;
        elem_w_stb = '0;
        unique case (phase_q)
            PH_READ:          bus_r_data = rdata_q;
            PH_COMMIT:        elem_w_stb = commit_q;
            PH_IDLE, PH_FILL: ;
            default:          ;
        endcase
    end

    // R6: an element write strobe is always caused by a bus write one cycle earlier
    assert_wstb_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_w_stb != '0) |-> $past(bus_w_stb));

    // R6: without a new bus write the element strobe is gone next cycle
    assert_wstb_no_stuck_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_w_stb |=> (elem_w_stb == '0));

    assert_wstb_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_w_stb));

    assert_rstb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_r_stb));

    // R3: element read strobe is followed by the read-return phase
    assert_rstb_then_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_r_stb != '0) |=> (phase_q == PH_READ));

    // R3: nonzero read data only in the cycle after an accepted read
    assert_rdata_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_r_data != '0) |-> $past(bus_r_stb && !bus_w_stb));

    assert_ro_no_wstb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_w_stb & ~CAN_WRITE) == '0);

    // R9: a write strobe suppresses every element read strobe
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_w_stb |-> (elem_r_stb == '0));

endmodule

// File: tb/csr_chunk_mux_bench.sv
module csr_chunk_mux_bench;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NE = 4;
    localparam int AL = 1;
    localparam int SW = 20;
    localparam int EW [NE] = '{4, 8, 16, 20};
    localparam bit [NE-1:0] CR  = 4'b1101;
    localparam bit [NE-1:0] CWR = 4'b1110;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_r_stb = 1'b0;
    logic [DW-1:0]     bus_r_data;
    logic              bus_w_stb = 1'b0;
    logic [DW-1:0]     bus_w_data = '0;
    logic [NE*SW-1:0]  elem_r_data;
    logic [NE-1:0]     elem_r_stb;
    logic [NE*SW-1:0]  elem_w_data;
    logic [NE-1:0]     elem_w_stb;

    logic [31:0] rv   [NE];
    logic [31:0] snap [NE];
    logic [31:0] wsh  [NE];
    logic [31:0] wexp [NE];

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NE; k++) elem_r_data[k*SW +: SW] = rv[k][SW-1:0];
    end

    csr_chunk_mux u_csr_chunk_mux (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_r_stb(bus_r_stb),
        .bus_r_data(bus_r_data), .bus_w_stb(bus_w_stb), .bus_w_data(bus_w_data),
        .elem_r_data(elem_r_data), .elem_r_stb(elem_r_stb),
        .elem_w_data(elem_w_data), .elem_w_stb(elem_w_stb)
    );

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int nch(input int k);
        return (EW[k] + DW - 1) / DW;
    endfunction

    function automatic int base(input int k);
        int acc, g;
        acc = 0;
        g = 1 << AL;
        for (int i = 0; i < k; i++) acc += ((nch(i) + g - 1) / g) * g;
        return acc;
    endfunction

    function automatic logic [31:0] mask(input int w);
        return (32'd1 << w) - 32'd1;
    endfunction

    function automatic void decode(input int a, output int e, output int ch, output bit hit);
        hit = 1'b0; e = 0; ch = 0;
        for (int k = 0; k < NE; k++) begin
            if (a >= base(k) && a < base(k) + nch(k)) begin
                hit = 1'b1; e = k; ch = a - base(k);
            end
        end
    endfunction

    function automatic logic [NE*SW-1:0] wvec();
        logic [NE*SW-1:0] v;
        for (int k = 0; k < NE; k++) v[k*SW +: SW] = wexp[k][SW-1:0];
        return v;
    endfunction

    task automatic do_write(input int a, input logic [7:0] d);
        int e, ch;
        bit hit;
        logic [NE-1:0] exp_stb;
        logic [31:0] t;
        string tag;
        decode(a, e, ch, hit);
        exp_stb = '0;
        if (hit && CWR[e]) begin
            t = wsh[e];
            t[ch*8 +: 8] = d;
            wsh[e] = t;
            if (ch == nch(e) - 1) begin
                exp_stb[e] = 1'b1;
                wexp[e] = t & mask(EW[e]);
                tag = "R1/R6";
            end else begin
                tag = "R5";
            end
        end else begin
            tag = hit ? "R8" : "R7";
        end
        @(negedge clk);
        bus_addr = AW'(a); bus_w_data = d; bus_w_stb = 1'b1;
        #1 chk("R9", "r_stb during write", 128'(elem_r_stb), 128'(0));
        @(negedge clk);
        bus_w_stb = 1'b0; bus_addr = AW'(a) ^ 8'hA5;
        chk(tag, $sformatf("w_stb addr %0d", a), 128'(elem_w_stb), 128'(exp_stb));
        chk(tag, $sformatf("w_data addr %0d", a), 128'(elem_w_data), 128'(wvec()));
        @(negedge clk);
        chk("R6", "w_stb one cycle only", 128'(elem_w_stb), 128'(0));
    endtask

    task automatic do_read(input int a);
        int e, ch;
        bit hit;
        logic [NE-1:0] exp_stb;
        logic [7:0] expd;
        string tag;
        for (int k = 0; k < NE; k++) rv[k] = (a * 4099 + k * 7919 + 32'h12345) & mask(EW[k]);
        decode(a, e, ch, hit);
        exp_stb = '0;
        expd = '0;
        if (hit && CR[e]) begin
            if (ch == 0) begin
                snap[e] = rv[e];
                exp_stb[e] = 1'b1;
            end
            expd = 8'(snap[e] >> (8 * ch));
            tag = (ch == 0) ? "R3 chunk0" : "R3 snapshot";
        end else begin
            tag = hit ? "R8" : "R7";
        end
        @(negedge clk);
        bus_addr = AW'(a); bus_r_stb = 1'b1;
        #1 chk("R2", $sformatf("r_stb addr %0d", a), 128'(elem_r_stb), 128'(exp_stb));
        @(negedge clk);
        bus_r_stb = 1'b0; bus_addr = AW'(a) ^ 8'h3C;
        chk(tag, $sformatf("r_data addr %0d", a), 128'(bus_r_data), 128'(expd));
        @(negedge clk);
        chk("R3", "r_data back to zero", 128'(bus_r_data), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NE; k++) begin
            rv[k] = '0; snap[k] = '0; wsh[k] = '0; wexp[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10", "w_stb after reset", 128'(elem_w_stb), 128'(0));
        chk("R10", "w_data after reset", 128'(elem_w_data), 128'(0));
        chk("R10", "r_data after reset", 128'(bus_r_data), 128'(0));
        chk("R10", "r_stb after reset", 128'(elem_r_stb), 128'(0));

        // R10: a higher chunk before any chunk-0 read returns the cleared shadow
        do_read(5);

        // R1 R5 R6 R7 R8: every address written once in ascending order
        for (int a = 0; a < 256; a++) do_write(a, 8'((a * 37 + 11) & 255));

        // R2 R3 R7 R8: every address read, element values change each read
        for (int a = 0; a < 256; a++) do_read(a);

        // R4: back-to-back reads, element values changed under the shadow
        rv[2] = 32'h0000C3E1;
        rv[3] = 32'h00098765;
        @(negedge clk);
        bus_addr = 8'd4; bus_r_stb = 1'b1;
        @(negedge clk);
        bus_addr = 8'd5; rv[2] = 32'h0;
        chk("R4", "pipelined read 1", 128'(bus_r_data), 128'(8'hE1));
        @(negedge clk);
        bus_addr = 8'd6;
        chk("R4", "pipelined read 2", 128'(bus_r_data), 128'(8'hC3));
        @(negedge clk);
        bus_addr = 8'd8; rv[3] = 32'h0;
        chk("R4", "pipelined read 3", 128'(bus_r_data), 128'(8'h65));
        @(negedge clk);
        bus_r_stb = 1'b0;
        chk("R4", "pipelined read 4", 128'(bus_r_data), 128'(8'h09));
        @(negedge clk);
        chk("R4", "idle after pipeline", 128'(bus_r_data), 128'(0));

        // R9: read and write strobes together on element 2 chunk 0
        rv[2] = 32'h0000BEEF;
        @(negedge clk);
        bus_addr = 8'd4; bus_r_stb = 1'b1; bus_w_stb = 1'b1; bus_w_data = 8'h3C;
        #1 chk("R9", "no r_stb on collision", 128'(elem_r_stb), 128'(0));
        @(negedge clk);
        bus_r_stb = 1'b0; bus_w_stb = 1'b0; bus_addr = 8'd0;
        chk("R9", "no read data on collision", 128'(bus_r_data), 128'(0));
        chk("R9", "no w_stb on collision", 128'(elem_w_stb), 128'(0));
        wsh[2][7:0] = 8'h3C;
        do_write(5, 8'h81);
        chk("R9", "collision write kept", 128'(elem_w_data[2*SW +: SW]), 128'(20'h0813C));

        // R6: 20-bit element assembled from three chunks, top bits dropped
        do_write(6, 8'h55);
        do_write(7, 8'hAA);
        do_write(9, 8'hDD);
        do_write(8, 8'h33);
        chk("R6", "20-bit assembly", 128'(elem_w_data[3*SW +: SW]), 128'(20'h3AA55));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule